// File: doc/BRIEF.md
# Crossbar Configuration Register Bank

This block sits behind a serial control bus whose bit framing is handled elsewhere. It receives whole bytes together with a start strobe and a stop strobe for each write transaction. The first byte after a start is a subaddress that picks one of three configuration registers. Every later byte in the same transaction is written to the register the pointer names. The pointer then advances, and after the third register it wraps back to the first.

The three registers configure a four-input, four-output switch matrix:

- **Routing register:** one 2-bit input select per output.
- **Control register:** a gain flag for each output, a clamp/mean-value choice for inputs 0 and 1, and two auxiliary logic outputs.
- **Output-enable register:** one enable per output.

The block drives all of these as plain outputs. To show the settings at work, it also contains a registered digital crossbar. This crossbar routes four sample streams, applies a saturating gain of two or a gain of one, and forces disabled outputs to zero.

Top module: `xbar_cfg_bank`

## Requirements
- R1: The first byte accepted after a start is a subaddress. Only its two low bits matter: 00 selects routing, 01 selects control and 10 selects output enable. The value 11 also selects routing, and the upper six bits are ignored.
- R2: A data byte is written to the register the pointer names, and the new value appears on the outputs after that clock edge. A byte with byteValid high is ignored when no transaction is open, or when busStart or busStop is high in the same cycle.
- R3: After each data byte the pointer advances from routing to control, then to output enable, then back to routing. A fourth data byte in a burst therefore rewrites the routing register.
- R4: busStop closes the transaction. After the next busStart, the first byte is again taken as a subaddress.
- R5: routeSel bits [2j+1:2j] come from routing register bits [2j+1:2j]. In the crossbar, select values 0 to 3 connect output j to input 0 to 3.
- R6: gainUnity[j] equals control bit 4+j. A 0 doubles the sample, saturating at all ones. A 1 passes the sample unchanged.
- R7: meanMode[i] equals control bit 2+i for input i. A 0 means clamping is enabled.
- R8: auxOut equals control bits 1:0 (0 drives low, 1 drives high).
- R9: outEnable equals output-enable register bits 3:0. Bits 7:4 of that byte are ignored, and a disabled output drives a zero sample.
- R10: Reset clears all three registers and sampleOut. As a result, all outputs route from input 0 at gain 2 with clamping on, and all outputs are disabled.
- R11: sampleOut is registered. It reflects the sampleIn and configuration present one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busStart | input | 1 | Start of a write transaction |
| busStop | input | 1 | End of a write transaction |
| byteValid | input | 1 | A received byte is present on byteData |
| byteData | input | 8 | Received byte |
| sampleIn | input | 4*SAMPLE_W | Four input samples, input i at [i*SAMPLE_W +: SAMPLE_W] |
| routeSel | output | 8 | Four 2-bit input selects |
| gainUnity | output | 4 | Per-output gain flag (1 = gain 1) |
| meanMode | output | 2 | Per-input clamp control (0 = clamp) |
| auxOut | output | 2 | Auxiliary logic outputs |
| outEnable | output | 4 | Per-output enable |
| sampleOut | output | 4*SAMPLE_W | Four output samples |

## Verification
The hardest situation to reach is a burst long enough to wrap the pointer. Such a burst must overwrite the routing register while the other two registers keep the values from earlier in the same burst. Timing corners are also hard to reach: stop and start arriving in the same cycle as a byte, and a subaddress of 11.

Directed bursts of four and more data bytes cover the wrap, and directed bursts with a subaddress of 11 cover that decode. After them come random transactions with random lengths, idle gaps, stray bytes outside transactions, and strobes that collide with bytes. A behavioural model follows the pointer and registers and is compared on every clock.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  localparam int NUM_IO   = 4;
  localparam int SEL_W    = $clog2(NUM_IO);
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 3;

  typedef enum logic [1:0] {
    REG_ROUTE  = 2'd0,
    REG_CTRL   = 2'd1,
    REG_ENABLE = 2'd2
  } regSel_e;

  typedef struct packed {
    logic              wrRoute;
    logic              wrCtrl;
    logic              wrEnable;
    logic [BYTE_W-1:0] wrData;
  } cfgStrobe_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output cfgStrobe_t        stb
);
  logic    inTx;
  logic    wantSub;
  regSel_e ptr;
  regSel_e subDecoded;
  regSel_e ptrNext;
  logic    acceptByte;

  // Strobes on the bus take priority over a byte in the same cycle.
  assign acceptByte = byteValid && inTx && !busStart && !busStop;

  // A subaddress low field of 11 falls back to the routing register.
  assign subDecoded = (byteData[1:0] == 2'b11) ? REG_ROUTE : regSel_e'(byteData[1:0]);
  assign ptrNext    = (ptr == REG_ENABLE) ? REG_ROUTE : regSel_e'(ptr + 2'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inTx    <= 1'b0;
      wantSub <= 1'b0;
      ptr     <= REG_ROUTE;
    end else if (busStart) begin
      inTx    <= 1'b1;
      wantSub <= 1'b1;
      ptr     <= REG_ROUTE;
    end else if (busStop) begin
      inTx    <= 1'b0;
      wantSub <= 1'b0;
    end else if (acceptByte) begin
      if (wantSub) begin
        wantSub <= 1'b0;
        ptr     <= subDecoded;
      end else begin
        ptr     <= ptrNext;
      end
    end
  end

  always_comb begin
    stb        = '0;
    stb.wrData = byteData;
    if (acceptByte && !wantSub) begin
      unique case (ptr)
        REG_ROUTE:  stb.wrRoute  = 1'b1;
        REG_CTRL:   stb.wrCtrl   = 1'b1;
        REG_ENABLE: stb.wrEnable = 1'b1;
        default:    stb.wrRoute  = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_cfg_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrobe_t                 stb,
  input  logic [NUM_IO*SAMPLE_W-1:0] sampleIn,
  output logic [NUM_IO*SEL_W-1:0]    routeSel,
  output logic [NUM_IO-1:0]          gainUnity,
  output logic [1:0]                 meanMode,
  output logic [1:0]                 auxOut,
  output logic [NUM_IO-1:0]          outEnable,
  output logic [NUM_IO*SAMPLE_W-1:0] sampleOut
);
  logic [BYTE_W-1:0]   routeReg;
  logic [BYTE_W-1:0]   ctrlReg;
  logic [NUM_IO-1:0]   enableReg;
  logic [SAMPLE_W-1:0] inArr [NUM_IO];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeReg  <= '0;
      ctrlReg   <= '0;
      enableReg <= '0;
    end else begin
      if (stb.wrRoute)  routeReg  <= stb.wrData;
      if (stb.wrCtrl)   ctrlReg   <= stb.wrData;
      if (stb.wrEnable) enableReg <= stb.wrData[NUM_IO-1:0];
    end
  end

  assign routeSel  = routeReg[NUM_IO*SEL_W-1:0];
  assign gainUnity = ctrlReg[7:4];
  assign meanMode  = ctrlReg[3:2];
  assign auxOut    = ctrlReg[1:0];
  assign outEnable = enableReg;

  for (genvar i = 0; i < NUM_IO; i++) begin : g_unpack
    assign inArr[i] = sampleIn[i*SAMPLE_W +: SAMPLE_W];
  end

  for (genvar j = 0; j < NUM_IO; j++) begin : g_lane
    logic [SEL_W-1:0]    sel;
    logic [SAMPLE_W-1:0] picked;
    logic [SAMPLE_W:0]   doubled;
    logic [SAMPLE_W-1:0] scaled;

    assign sel     = routeReg[j*SEL_W +: SEL_W];
    assign picked  = inArr[sel];
    assign doubled = {picked, 1'b0};
    assign scaled  = gainUnity[j] ? picked
                   : (doubled[SAMPLE_W] ? {SAMPLE_W{1'b1}} : doubled[SAMPLE_W-1:0]);

    always_ff @(posedge clk) begin
      if (!rstN) sampleOut[j*SAMPLE_W +: SAMPLE_W] <= '0;
      else       sampleOut[j*SAMPLE_W +: SAMPLE_W] <= enableReg[j] ? scaled : '0;
    end
  end
endmodule

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank
  import xbar_cfg_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busStart,
  input  logic                       busStop,
  input  logic                       byteValid,
  input  logic [7:0]                 byteData,
  input  logic [4*SAMPLE_W-1:0]      sampleIn,
  output logic [7:0]                 routeSel,
  output logic [3:0]                 gainUnity,
  output logic [1:0]                 meanMode,
  output logic [1:0]                 auxOut,
  output logic [3:0]                 outEnable,
  output logic [4*SAMPLE_W-1:0]      sampleOut
);
  cfgStrobe_t stb;

  xbar_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busStart (busStart),
    .busStop  (busStop),
    .byteValid(byteValid),
    .byteData (byteData),
    .stb      (stb)
  );

  xbar_datapath #(.SAMPLE_W(SAMPLE_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sampleIn (sampleIn),
    .routeSel (routeSel),
    .gainUnity(gainUnity),
    .meanMode (meanMode),
    .auxOut   (auxOut),
    .outEnable(outEnable),
    .sampleOut(sampleOut)
  );
endmodule

// File: rtl/xbar_cfg_bank_chk.sv
module xbar_cfg_bank_chk
  import xbar_cfg_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  byteValid,
  input cfgStrobe_t            stb,
  input logic [7:0]            routeSel,
  input logic [3:0]            gainUnity,
  input logic [3:0]            outEnable,
  input logic [4*SAMPLE_W-1:0] sampleOut
);
  // R3: at most one register is written per byte
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrRoute, stb.wrCtrl, stb.wrEnable}));

  // R2: a write strobe needs a byte on the bus
  a_r2_write_needs_byte: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrRoute || stb.wrCtrl || stb.wrEnable) |-> byteValid);

  // R2: routing holds when not addressed
  a_r2_route_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrRoute |=> $stable(routeSel));

  // R6: gain flags hold when not addressed
  a_r6_gain_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCtrl |=> $stable(gainUnity));

  for (genvar j = 0; j < 4; j++) begin : g_off
    // R9: a disabled lane drives zero on the next cycle
    a_r9_disabled_zero: assert property (@(posedge clk) disable iff (!rstN)
      !outEnable[j] |=> (sampleOut[j*SAMPLE_W +: SAMPLE_W] == '0));
  end
endmodule

bind xbar_cfg_bank xbar_cfg_bank_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .byteValid(byteValid),
  .stb      (stb),
  .routeSel (routeSel),
  .gainUnity(gainUnity),
  .outEnable(outEnable),
  .sampleOut(sampleOut)
);

// File: tb/sim_xbar_cfg_bank.sv
`timescale 1ns/1ps
module sim_xbar_cfg_bank;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busStart = 1'b0, busStop = 1'b0, byteValid = 1'b0;
  logic [7:0]    byteData = '0;
  logic [4*SW-1:0] sampleIn = '0;
  logic [7:0]    routeSel;
  logic [3:0]    gainUnity, outEnable;
  logic [1:0]    meanMode, auxOut;
  logic [4*SW-1:0] sampleOut;

  int nTests = 0, nFail = 0;
  bit holdSample = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  int mRoute = 0, mCtrl = 0, mEn = 0, mInTx = 0, mWantSub = 0, mPtr = 0;
  int expOut [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  xbar_cfg_bank #(.SAMPLE_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .byteValid(byteValid), .byteData(byteData), .sampleIn(sampleIn),
    .routeSel(routeSel), .gainUnity(gainUnity), .meanMode(meanMode),
    .auxOut(auxOut), .outEnable(outEnable), .sampleOut(sampleOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mRoute = 0; mCtrl = 0; mEn = 0; mInTx = 0; mWantSub = 0; mPtr = 0;
      for (int j = 0; j < 4; j++) expOut[j] = 0;
    end else begin
      for (int j = 0; j < 4; j++) begin
        int sel, s;
        sel = (mRoute >> (2 * j)) & 3;
        s = (sampleIn >> (sel * SW)) & 255;
        if (((mCtrl >> (4 + j)) & 1) == 0) s = (s * 2 > 255) ? 255 : s * 2;
        expOut[j] = ((mEn >> j) & 1) ? s : 0;
      end
      if (busStart) begin
        mInTx = 1; mWantSub = 1; mPtr = 0;
      end else if (busStop) begin
        mInTx = 0; mWantSub = 0;
      end else if (byteValid && mInTx == 1) begin
        if (mWantSub == 1) begin
          mWantSub = 0;
          mPtr = (byteData[1:0] == 2'b11) ? 0 : int'(byteData[1:0]);
        end else begin
          if (mPtr == 0) mRoute = byteData;
          else if (mPtr == 1) mCtrl = byteData;
          else mEn = byteData & 15;
          mPtr = (mPtr + 1) % 3;
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R5 routeSel", routeSel, mRoute);
      check("R6 gainUnity", gainUnity, (mCtrl >> 4) & 15);
      check("R7 meanMode", meanMode, (mCtrl >> 2) & 3);
      check("R8 auxOut", auxOut, mCtrl & 3);
      check("R9 outEnable", outEnable, mEn);
      for (int j = 0; j < 4; j++)
        check("R11 sampleOut", sampleOut[j*SW +: SW], expOut[j]);
    end
    if (!holdSample) sampleIn = {$urandom, $urandom} & {(4*SW){1'b1}};
  end

  task automatic cyc(input bit st, input bit sp, input bit bv, input logic [7:0] d);
    @(negedge clk);
    busStart = st; busStop = sp; byteValid = bv; byteData = d;
  endtask
  task automatic idle();
    cyc(0, 0, 0, 8'h00);
  endtask
  task automatic putByte(input logic [7:0] d);
    cyc(0, 0, 1, d);
  endtask

  initial begin
    #(200000 * 5);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 route reset", routeSel, 0);
    check("R10 ctrl reset", {gainUnity, meanMode, auxOut}, 0);
    check("R10 enable reset", outEnable, 0);
    check("R10 sample reset", sampleOut, 0);
    @(negedge clk); rstN = 1'b1;

    // R3: four data bytes wrap onto routing
    cyc(1, 0, 0, 0); putByte(8'h00);
    putByte(8'hE4); putByte(8'h5A); putByte(8'h0F); putByte(8'h1B);
    cyc(0, 1, 0, 0); idle();
    check("R3 wrap rewrote routing", routeSel, 8'h1B);
    check("R6 gain from 5A", gainUnity, 4'h5);
    check("R7 clamp from 5A", meanMode, 2'b10);
    check("R8 aux from 5A", auxOut, 2'b10);
    check("R9 enable", outEnable, 4'hF);

    // R2: byte outside a transaction ignored
    putByte(8'hFF); idle();
    check("R2 stray byte ignored", routeSel, 8'h1B);

    // R1: subaddress 11 selects routing; upper bits ignored
    cyc(1, 0, 0, 0); putByte(8'hFF); putByte(8'h93); cyc(0, 1, 0, 0); idle();
    check("R1 sub 11 to routing", routeSel, 8'h93);
    cyc(1, 0, 0, 0); putByte(8'hFE); putByte(8'hF5); cyc(0, 1, 0, 0); idle();
    check("R9 high nibble ignored", outEnable, 4'h5);

    // R4: new transaction restarts with a subaddress
    cyc(1, 0, 0, 0); putByte(8'h01); putByte(8'h33); cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0); putByte(8'h02); putByte(8'h0C); cyc(0, 1, 0, 0); idle();
    check("R4 ctrl kept", {gainUnity, meanMode, auxOut}, 8'h33);
    check("R4 enable via fresh sub", outEnable, 4'hC);

    // R2: byte colliding with stop is dropped
    cyc(1, 0, 0, 0); putByte(8'h00); cyc(0, 1, 1, 8'h44); idle();
    check("R2 byte with stop ignored", routeSel, 8'h93);

    // R6/R11: saturation and pass-through
    cyc(1, 0, 0, 0); putByte(8'h00); putByte(8'h00); putByte(8'h20); putByte(8'h0F);
    cyc(0, 1, 0, 0);
    holdSample = 1'b1;
    @(negedge clk); sampleIn = {8'h00, 8'h00, 8'h21, 8'h90};
    @(negedge clk);
    check("R6 gain2 saturates", sampleOut[7:0], 8'hFF);
    check("R6 gain1 passes", sampleOut[15:8], 8'h90);
    cyc(1, 0, 0, 0); putByte(8'h00); putByte(8'h01); cyc(0, 1, 0, 0);
    @(negedge clk);
    check("R5 out0 from input 1 doubled", sampleOut[7:0], 8'h42);
    holdSample = 1'b0;

    // random traffic checked by the model every cycle
    for (int t = 0; t < 300; t++) begin
      int len;
      len = $urandom_range(0, 8);
      cyc(1, 0, $urandom_range(0, 1), $urandom);
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(0, 4) == 0) idle();
        putByte($urandom);
      end
      cyc(0, 1, $urandom_range(0, 1), $urandom);
      if ($urandom_range(0, 2) == 0) putByte($urandom);
      idle();
    end

    idle(); idle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule